// File: doc/BRIEF.md
# Graded Special-Instruction Dispatch and Trap Unit

This unit sits beside a core pipeline that issues special instructions (SIs) to a set of reconfigurable accelerator datapaths. Each SI needs three kinds of datapath: a byte-subtract unit, a repack unit and a transform unit. At issue time the unit compares the loaded count of each kind with the count that full hardware execution needs. If every count meets its requirement, the unit signals hardware execution. Otherwise it raises an "unimplemented SI" trap. A count of zero covers two cases: the reconfiguration is still in progress, or the run-time manager chose not to accelerate this SI.

A trap does not have to fall back to pure software. The unit picks a software-assisted variant index from the datapath types that are present. The trap handler can then use whatever partial hardware is already loaded. The counts are sampled on every issue, so a datapath that finishes loading helps the very next issue. Nothing waits for the whole set.

For the handler, the unit provides three kinds of support. It copies the SI opcode out of the instruction word and presents it right-aligned. It latches the two source operands and the two destination register indices into temporary storage. It then writes up to two emulation results into those destination registers through a valid/acknowledge handshake.

Top module: `si_dispatch_unit`

## Requirements
- R1: On a trap, instruction bits 28..24 are captured and presented on `opcodeOut` bits 4..0, with bits 31..5 zero. The value holds until the next trap.
- R2: An accepted issue asserts `hwExec` for exactly one cycle, one clock after the issue edge, if all three required counts are met. The requirements are subtract >= 1, repack >= 1 and transform >= 2. In that case `trapRaise` stays low and `variantIdx` is 0.
- R3: An accepted issue that does not meet every requirement asserts `trapRaise` for exactly one cycle, one clock after the issue edge.
- R4: `dpCounts` packs the counts as transform in bits 2..0, repack in bits 5..3 and subtract in bits 8..6. On a trap, `variantIdx` is 1 plus the number of consecutive nonzero counts taken in the order transform, repack, subtract. This gives the following:
  - all zero gives 1;
  - transform only gives 2;
  - transform and repack gives 3;
  - all three nonzero but below the requirement gives 4;
  - no transform gives 1, whatever else is loaded.
- R5: On a trap, `opA` and `opB` are latched into `tmpOpA` and `tmpOpB` and held unchanged until the next trap.
- R6: On a trap, instruction bits 15..11 and 10..6 are latched as the first and second destination register indices.
- R7: While a trap is pending, `wbValid` is acknowledged in the same cycle. The acknowledge writes `wbData0` to the first destination (`rfWe0`). It writes `wbData1` to the second destination (`rfWe1`) only when `wbTwo` is 1.
- R8: While a trap is pending, issues are ignored. No `hwExec`, no `trapRaise`, and the latched operands stay unchanged. The acknowledged write-back ends the pending state.
- R9: `wbValid` with no trap pending is ignored: no acknowledge and no register write.
- R10: The counts are sampled on each issue. Raising a count between two issues changes the decision for the second issue.
- R11: `hwExec` and `trapRaise` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | SI issued this cycle |
| instrWord | input | 32 | SI instruction word |
| opA | input | 32 | First source operand |
| opB | input | 32 | Second source operand |
| dpCounts | input | 9 | Loaded datapath counts, 3 bits per type |
| wbValid | input | 1 | Emulation result ready |
| wbTwo | input | 1 | Second result also valid |
| wbData0 | input | 32 | First result |
| wbData1 | input | 32 | Second result |
| hwExec | output | 1 | Execute in hardware (pulse) |
| trapRaise | output | 1 | Unimplemented-SI trap (pulse) |
| variantIdx | output | 3 | Software variant index |
| opcodeOut | output | 32 | Right-aligned SI opcode |
| tmpOpA | output | 32 | Latched first operand |
| tmpOpB | output | 32 | Latched second operand |
| wbAck | output | 1 | Write-back accepted |
| rfWe0 | output | 1 | Register write enable, first result |
| rfWaddr0 | output | 5 | First destination index |
| rfWdata0 | output | 32 | First write data |
| rfWe1 | output | 1 | Register write enable, second result |
| rfWaddr1 | output | 5 | Second destination index |
| rfWdata1 | output | 32 | Second write data |

## Verification
The bench builds the unit with its defaults. These are 3-bit counts and a transform requirement of two. With that requirement, the fourth variant can occur: all three types are present, but the transform count is still short. The width makes counts up to seven reachable, so random stimulus covers both the comparisons against the requirement and the zero tests. With a requirement of one everywhere, the all-present trap case would be unreachable.

// File: rtl/si_dispatch_pkg.sv
package si_dispatch_pkg;

  typedef enum logic {
    ST_IDLE,
    ST_EMUL
  } dispState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchTrap;
    logic wbFire;
    logic wbSecond;
  } ctrlStrobe_t;

endpackage

// File: rtl/si_dispatch_ctrl.sv
module si_dispatch_ctrl
  import si_dispatch_pkg::*;
#(
  parameter int CNT_W     = 3,
  parameter int NUM_TYPES = 3,
  // required counts, index 0 = transform, 1 = repack, 2 = subtract
  parameter logic [NUM_TYPES*CNT_W-1:0] REQ_COUNTS = {3'd1, 3'd1, 3'd2},
  localparam int VAR_W = $clog2(NUM_TYPES + 2)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       issueValid,
  input  logic [NUM_TYPES*CNT_W-1:0] dpCounts,
  input  logic                       wbValid,
  input  logic                       wbTwo,
  output logic                       hwExec,
  output logic                       trapRaise,
  output logic [VAR_W-1:0]           variantIdx,
  output logic                       wbAck,
  output ctrlStrobe_t                strobe
);

  dispState_t       state;
  logic [NUM_TYPES-1:0] present;
  logic [NUM_TYPES-1:0] enough;
  logic             allEnough;
  logic [VAR_W-1:0] chainLen;
  logic [VAR_W-1:0] variantNext;
  logic             accept;

  for (genvar t = 0; t < NUM_TYPES; t++) begin : g_type
    assign present[t] = dpCounts[t*CNT_W +: CNT_W] != '0;
    assign enough[t]  = dpCounts[t*CNT_W +: CNT_W] >= REQ_COUNTS[t*CNT_W +: CNT_W];
  end

  assign allEnough = &enough;

  always_comb begin
    logic run;
    run      = 1'b1;
    chainLen = '0;
    for (int t = 0; t < NUM_TYPES; t++) begin
      if (run && present[t]) chainLen = chainLen + 1'b1;
      else                   run      = 1'b0;
    end
    variantNext = chainLen + 1'b1;
  end

  assign accept = issueValid && (state == ST_IDLE);

  always_comb begin
    strobe.latchTrap = accept && !allEnough;
    strobe.wbFire    = (state == ST_EMUL) && wbValid;
    strobe.wbSecond  = (state == ST_EMUL) && wbValid && wbTwo;
  end

  assign wbAck = strobe.wbFire;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      hwExec     <= 1'b0;
      trapRaise  <= 1'b0;
      variantIdx <= '0;
    end else begin
      hwExec    <= accept && allEnough;
      trapRaise <= accept && !allEnough;
      if (accept) begin
        variantIdx <= allEnough ? '0 : variantNext;
        state      <= allEnough ? ST_IDLE : ST_EMUL;
      end else if (strobe.wbFire) begin
        state <= ST_IDLE;
      end
    end
  end

  // R11
  exclusive_outcome_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(hwExec && trapRaise));

  // R2
  issue_resolves_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> (hwExec ^ trapRaise));

  // R4
  variant_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapRaise |-> (variantIdx != '0 && variantIdx <= VAR_W'(NUM_TYPES + 1)));

  // R8
  pending_blocks_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_EMUL && !wbValid) |=> !hwExec && !trapRaise);

endmodule

// File: rtl/si_dispatch_dp.sv
module si_dispatch_dp
  import si_dispatch_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 5,
  parameter int OPC_LSB  = 24,
  parameter int OPC_W    = 5,
  parameter int DST0_LSB = 11,
  parameter int DST1_LSB = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] instrWord,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] wbData0,
  input  logic [DATA_W-1:0] wbData1,
  output logic [DATA_W-1:0] opcodeOut,
  output logic [DATA_W-1:0] tmpOpA,
  output logic [DATA_W-1:0] tmpOpB,
  output logic              rfWe0,
  output logic [IDX_W-1:0]  rfWaddr0,
  output logic [DATA_W-1:0] rfWdata0,
  output logic              rfWe1,
  output logic [IDX_W-1:0]  rfWaddr1,
  output logic [DATA_W-1:0] rfWdata1
);

  logic [OPC_W-1:0] opcodeQ;
  logic [IDX_W-1:0] dst0Q;
  logic [IDX_W-1:0] dst1Q;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opcodeQ <= '0;
      tmpOpA  <= '0;
      tmpOpB  <= '0;
      dst0Q   <= '0;
      dst1Q   <= '0;
    end else if (strobe.latchTrap) begin
      opcodeQ <= instrWord[OPC_LSB +: OPC_W];
      tmpOpA  <= opA;
      tmpOpB  <= opB;
      dst0Q   <= instrWord[DST0_LSB +: IDX_W];
      dst1Q   <= instrWord[DST1_LSB +: IDX_W];
    end
  end

  assign opcodeOut = {{(DATA_W - OPC_W){1'b0}}, opcodeQ};
  assign rfWe0     = strobe.wbFire;
  assign rfWe1     = strobe.wbSecond;
  assign rfWaddr0  = dst0Q;
  assign rfWaddr1  = dst1Q;
  assign rfWdata0  = wbData0;
  assign rfWdata1  = wbData1;

  // R7
  second_needs_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    rfWe1 |-> rfWe0);

  // R5
  operand_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchTrap |=> (tmpOpA == $past(opA) && tmpOpB == $past(opB)));

  // R5
  operand_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.latchTrap |=> ($stable(tmpOpA) && $stable(tmpOpB) && $stable(opcodeOut)));

endmodule

// File: rtl/si_dispatch_unit.sv
module si_dispatch_unit
  import si_dispatch_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 3,
  parameter int NUM_TYPES = 3,
  parameter int IDX_W     = 5,
  parameter logic [NUM_TYPES*CNT_W-1:0] REQ_COUNTS = {3'd1, 3'd1, 3'd2}
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              issueValid,
  input  logic [DATA_W-1:0]                 instrWord,
  input  logic [DATA_W-1:0]                 opA,
  input  logic [DATA_W-1:0]                 opB,
  input  logic [NUM_TYPES*CNT_W-1:0]        dpCounts,
  input  logic                              wbValid,
  input  logic                              wbTwo,
  input  logic [DATA_W-1:0]                 wbData0,
  input  logic [DATA_W-1:0]                 wbData1,
  output logic                              hwExec,
  output logic                              trapRaise,
  output logic [$clog2(NUM_TYPES+2)-1:0]    variantIdx,
  output logic [DATA_W-1:0]                 opcodeOut,
  output logic [DATA_W-1:0]                 tmpOpA,
  output logic [DATA_W-1:0]                 tmpOpB,
  output logic                              wbAck,
  output logic                              rfWe0,
  output logic [IDX_W-1:0]                  rfWaddr0,
  output logic [DATA_W-1:0]                 rfWdata0,
  output logic                              rfWe1,
  output logic [IDX_W-1:0]                  rfWaddr1,
  output logic [DATA_W-1:0]                 rfWdata1
);

  ctrlStrobe_t strobe;

  si_dispatch_ctrl #(
    .CNT_W      (CNT_W),
    .NUM_TYPES  (NUM_TYPES),
    .REQ_COUNTS (REQ_COUNTS)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .issueValid (issueValid),
    .dpCounts   (dpCounts),
    .wbValid    (wbValid),
    .wbTwo      (wbTwo),
    .hwExec     (hwExec),
    .trapRaise  (trapRaise),
    .variantIdx (variantIdx),
    .wbAck      (wbAck),
    .strobe     (strobe)
  );

  si_dispatch_dp #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .instrWord (instrWord),
    .opA       (opA),
    .opB       (opB),
    .wbData0   (wbData0),
    .wbData1   (wbData1),
    .opcodeOut (opcodeOut),
    .tmpOpA    (tmpOpA),
    .tmpOpB    (tmpOpB),
    .rfWe0     (rfWe0),
    .rfWaddr0  (rfWaddr0),
    .rfWdata0  (rfWdata0),
    .rfWe1     (rfWe1),
    .rfWaddr1  (rfWaddr1),
    .rfWdata1  (rfWdata1)
  );

endmodule

// File: tb/si_dispatch_unit_tb_top.sv
`timescale 1ns/1ps
module si_dispatch_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [8:0]  dpCounts = '0;
  logic        wbValid = 1'b0;
  logic        wbTwo = 1'b0;
  logic [31:0] wbData0 = '0;
  logic [31:0] wbData1 = '0;
  logic        hwExec, trapRaise, wbAck, rfWe0, rfWe1;
  logic [2:0]  variantIdx;
  logic [31:0] opcodeOut, tmpOpA, tmpOpB, rfWdata0, rfWdata1;
  logic [4:0]  rfWaddr0, rfWaddr1;

  int testCnt = 0;
  int failCnt = 0;

  // bench model state
  logic        pend = 1'b0;
  logic [31:0] expOpc = '0, expA = '0, expB = '0;
  logic [4:0]  expD0 = '0, expD1 = '0;

  always #4 clk = ~clk;

  si_dispatch_unit dut_i (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .instrWord(instrWord),
    .opA(opA), .opB(opB), .dpCounts(dpCounts), .wbValid(wbValid), .wbTwo(wbTwo),
    .wbData0(wbData0), .wbData1(wbData1), .hwExec(hwExec), .trapRaise(trapRaise),
    .variantIdx(variantIdx), .opcodeOut(opcodeOut), .tmpOpA(tmpOpA), .tmpOpB(tmpOpB),
    .wbAck(wbAck), .rfWe0(rfWe0), .rfWaddr0(rfWaddr0), .rfWdata0(rfWdata0),
    .rfWe1(rfWe1), .rfWaddr1(rfWaddr1), .rfWdata1(rfWdata1)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // expected variant: 0 = hardware, else chain length + 1
  function automatic logic [2:0] expVariant(input logic [2:0] sub, input logic [2:0] rep,
                                            input logic [2:0] xf);
    if (sub >= 1 && rep >= 1 && xf >= 2) return 3'd0;
    if (xf == 0)  return 3'd1;
    if (rep == 0) return 3'd2;
    if (sub == 0) return 3'd3;
    return 3'd4;
  endfunction

  task automatic doIssue(input logic [2:0] sub, input logic [2:0] rep, input logic [2:0] xf,
                         input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
    logic [2:0] ev;
    ev = expVariant(sub, rep, xf);
    @(negedge clk);
    issueValid = 1'b1; instrWord = ins; opA = a; opB = b;
    dpCounts = {sub, rep, xf};
    @(negedge clk);
    issueValid = 1'b0;
    if (pend) begin
      check("R8 ignored hwExec", {31'd0, hwExec}, 32'd0);
      check("R8 ignored trap", {31'd0, trapRaise}, 32'd0);
      check("R8 tmpOpA kept", tmpOpA, expA);
    end else begin
      check("R2 hwExec", {31'd0, hwExec}, {31'd0, ev == 3'd0});
      check("R3 trapRaise", {31'd0, trapRaise}, {31'd0, ev != 3'd0});
      check("R4 variant", {29'd0, variantIdx}, {29'd0, ev});
      check("R11 exclusive", {31'd0, hwExec & trapRaise}, 32'd0);
      if (ev != 3'd0) begin
        pend   = 1'b1;
        expOpc = {27'd0, ins[28:24]};
        expA = a; expB = b; expD0 = ins[15:11]; expD1 = ins[10:6];
      end
      check("R1 opcode", opcodeOut, expOpc);
      check("R5 tmpOpA", tmpOpA, expA);
      check("R5 tmpOpB", tmpOpB, expB);
      @(negedge clk);
      check("R2 R3 pulse", {30'd0, hwExec, trapRaise}, 32'd0);
    end
  endtask

  task automatic doWb(input logic two, input logic [31:0] d0, input logic [31:0] d1);
    @(negedge clk);
    wbValid = 1'b1; wbTwo = two; wbData0 = d0; wbData1 = d1;
    #1;
    if (pend) begin
      check("R7 ack", {31'd0, wbAck}, 32'd1);
      check("R7 we0", {31'd0, rfWe0}, 32'd1);
      check("R7 we1", {31'd0, rfWe1}, {31'd0, two});
      check("R6 addr0", {27'd0, rfWaddr0}, {27'd0, expD0});
      check("R6 addr1", {27'd0, rfWaddr1}, {27'd0, expD1});
      check("R7 data0", rfWdata0, d0);
      if (two) check("R7 data1", rfWdata1, d1);
    end else begin
      check("R9 no ack", {31'd0, wbAck}, 32'd0);
      check("R9 no write", {30'd0, rfWe0, rfWe1}, 32'd0);
    end
    @(negedge clk);
    wbValid = 1'b0; wbTwo = 1'b0;
    pend = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    failCnt++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R2 reset hwExec", {31'd0, hwExec}, 32'd0);
    check("R3 reset trap", {31'd0, trapRaise}, 32'd0);
    check("R1 reset opcode", opcodeOut, 32'd0);
    check("R7 reset we", {30'd0, rfWe0, rfWe1}, 32'd0);

    // R4 directed subsets
    doIssue(3'd0, 3'd0, 3'd0, 32'hFFFF_FFFF, 32'h1111_0001, 32'h2222_0001); doWb(1'b1, 32'hA0, 32'hB0);
    doIssue(3'd0, 3'd0, 3'd1, 32'h0A00_5A40, 32'h1111_0002, 32'h2222_0002); doWb(1'b0, 32'hA1, 32'hB1);
    doIssue(3'd0, 3'd3, 3'd1, 32'h1300_0840, 32'h1111_0003, 32'h2222_0003); doWb(1'b1, 32'hA2, 32'hB2);
    doIssue(3'd1, 3'd1, 3'd1, 32'hE100_F7C0, 32'h1111_0004, 32'h2222_0004); doWb(1'b1, 32'hA3, 32'hB3);
    doIssue(3'd1, 3'd1, 3'd2, 32'h0500_0000, 32'h1111_0005, 32'h2222_0005);
    doIssue(3'd7, 3'd7, 3'd0, 32'h0600_0000, 32'h1111_0006, 32'h2222_0006); doWb(1'b0, 32'hA4, 32'hB4);
    doIssue(3'd2, 3'd0, 3'd4, 32'h0700_0000, 32'h1111_0007, 32'h2222_0007); doWb(1'b1, 32'hA5, 32'hB5);

    // R10 upgrade: transform count grows from 1 to 2 between issues
    doIssue(3'd1, 3'd1, 3'd1, 32'h0800_1000, 32'h3333_0001, 32'h4444_0001); doWb(1'b0, 32'hC0, 32'hC1);
    doIssue(3'd1, 3'd1, 3'd2, 32'h0900_1000, 32'h3333_0002, 32'h4444_0002);
    check("R10 upgrade reaches hw", {29'd0, variantIdx}, 32'd0);

    // R8 issue while pending, R9 write-back while idle
    doIssue(3'd0, 3'd0, 3'd0, 32'h0A00_0000, 32'h5555_0001, 32'h6666_0001);
    doIssue(3'd7, 3'd7, 3'd7, 32'h0B00_0000, 32'h5555_0002, 32'h6666_0002);
    doWb(1'b1, 32'hD0, 32'hD1);
    doWb(1'b1, 32'hD2, 32'hD3);

    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [2:0] s, r, x;
      s = 3'($urandom_range(0, 7)); r = 3'($urandom_range(0, 7)); x = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 1) == 0) s = 3'd0;
      if ($urandom_range(0, 2) == 0) x = 3'($urandom_range(0, 1));
      doIssue(s, r, x, $urandom, $urandom, $urandom);
      if (pend || $urandom_range(0, 3) == 0)
        doWb(1'($urandom_range(0, 1)), $urandom, $urandom);
    end

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule